// File: doc/BRIEF.md
# Paged Host Register File with Remote Byte DMA

This block is the host-facing register window of a small network controller. A host drives an 8-bit data bus with a 5-bit offset, one-cycle write and read strobes. Offset 0 always reaches the command register. The two page-select bits of that register choose which bank answers the other low offsets, and a given offset can mean one register when written and another when read.

A data port at offset 0x10 moves bytes between the host and a local synchronous RAM. A remote DMA engine is loaded with a 16-bit start address and a 16-bit byte count, then armed by a command write. Each data-port access moves one byte, steps the address up and the count down. When the count runs out the engine stops and raises a completion flag in the interrupt status register. The interrupt mask register gates that flag onto the interrupt line. A write of any value to offset 0x1F restores the command and status registers without touching the configuration.

Top module: `nic_host_regs`

## Requirements
- R1: After `rst_n` is released the command register reads 0x21 (page bits 7:6 = 00, no-DMA bit 5 = 1, stop bit 0 = 1), interrupt status reads 0x00 and `irq` is low.
- R2: Offset 0 reads and writes the command register whatever page is selected. Command bits 7:6 select the bank: 00 is page 0, 01 is page 1, and 10 is a read-only view of the page 0 configuration. Writes to offsets 1-15 in pages 2 and 3 are ignored, and reads of any offset other than 0 in page 3 return 0x00.
- R3: Page 0 writes set these registers: page start at 1, remote start address low/high at 8/9, remote byte count low/high at 0x0A/0x0B, receive config at 0x0C, transmit config at 0x0D, data config at 0x0E and interrupt mask at 0x0F. Page 0 reads return the page start at 1, the current remote address at 8/9 and the remaining count at 0x0A/0x0B. All other page 0 reads except 0, 7 and 0x0C return 0x00.
- R4: Offset 0x0C differs by direction. In page 0 a read returns the `rx_stat` input and a write sets the receive config. Page 2 reads return the receive config at 0x0C, the transmit config at 0x0D, the data config at 0x0E, the interrupt mask at 0x0F and the page start at 1. All other page 2 offsets read 0x00.
- R5: Page 1 offsets 1-6 hold six station-address bytes and offsets 8-15 hold eight multicast-filter bytes, all readable and writable. Page 1 offset 7 reads 0x00.
- R6: Writing the command register with bits 5:3 = 001 (for example 0x0A) starts a remote read. Each data-port read then fetches the RAM byte at the remote address, which appears on `host_rdata` one cycle after the strobe. The address increments with carry across all 16 bits and the count decrements.
- R7: Writing the command register with bits 5:3 = 010 (for example 0x12) starts a remote write. Each data-port write stores `host_wdata` at the remote address, then the address steps up and the count steps down.
- R8: When the count reaches zero, or when a start is issued with a count of zero, the engine goes idle, command bits 5:3 become 100 and status bit 6 sets. While the engine is idle, data-port accesses do not touch the RAM or the address, and data-port reads return 0x00.
- R9: `irq` is high exactly when some status bit is set whose interrupt-mask bit (same position) is also set.
- R10: A page 0 write to offset 7 clears each status bit whose data bit is 1 and leaves the others unchanged.
- R11: Any write to offset 0x1F sets the command register to 0x21, clears the status register and stops the engine. The configuration, address and filter registers keep their values.
- R12: A register read returns its value on `host_rdata` in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 5 | Register offset |
| host_wr | input | 1 | Write strobe, one cycle per byte |
| host_rd | input | 1 | Read strobe, one cycle per byte |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid the cycle after a read strobe |
| irq | output | 1 | Masked interrupt request |
| rx_stat | input | 8 | Receive status from the receive path |
| mem_addr | output | 16 | Local RAM address |
| mem_rd | output | 1 | Local RAM read enable |
| mem_wr | output | 1 | Local RAM write enable |
| mem_wdata | output | 8 | Local RAM write data |
| mem_rdata | input | 8 | Local RAM read data, one cycle after `mem_rd` |

## Verification
The bench writes a distinct value to every writable offset in all four pages and reads back all 32 offsets in every page. This tells the banks apart, shows which writes are ignored, and shows where read and write meanings differ. One remote read starts just below a 256-byte boundary, which checks the carry into the high address byte and the fetched contents. One remote write is then read back through the bench RAM. A start with a zero count, a data-port access after completion, status clearing with and without the clear bit, and a reset-port write each check a single edge of the completion and recovery logic.

// File: rtl/nic_regs_pkg.sv
package nic_regs_pkg;
    localparam int OFF_W  = 5;
    localparam int BYTE_W = 8;
    localparam int RA_W   = 16;
    localparam int STA_N  = 6;
    localparam int MC_N   = 8;

    localparam logic [OFF_W-1:0] OFF_CMD    = 5'h00;
    localparam logic [OFF_W-1:0] OFF_PSTART = 5'h01;
    localparam logic [OFF_W-1:0] OFF_ISR    = 5'h07;
    localparam logic [OFF_W-1:0] OFF_RA_LO  = 5'h08;
    localparam logic [OFF_W-1:0] OFF_RA_HI  = 5'h09;
    localparam logic [OFF_W-1:0] OFF_RC_LO  = 5'h0A;
    localparam logic [OFF_W-1:0] OFF_RC_HI  = 5'h0B;
    localparam logic [OFF_W-1:0] OFF_RXCFG  = 5'h0C;
    localparam logic [OFF_W-1:0] OFF_TXCFG  = 5'h0D;
    localparam logic [OFF_W-1:0] OFF_DCFG   = 5'h0E;
    localparam logic [OFF_W-1:0] OFF_IMASK  = 5'h0F;
    localparam logic [OFF_W-1:0] OFF_DATA   = 5'h10;
    localparam logic [OFF_W-1:0] OFF_SRST   = 5'h1F;

    localparam logic [BYTE_W-1:0] CMD_INIT  = 8'h21;
    localparam logic [2:0]        XF_READ   = 3'b001;
    localparam logic [2:0]        XF_WRITE  = 3'b010;
    localparam logic [2:0]        XF_DONE   = 3'b100;
    localparam int                DONE_BIT  = 6;

    typedef struct packed {
        logic [BYTE_W-1:0] cmd;
        logic [BYTE_W-1:0] pstart;
        logic [BYTE_W-1:0] rxcfg;
        logic [BYTE_W-1:0] txcfg;
        logic [BYTE_W-1:0] dcfg;
        logic [BYTE_W-1:0] imask;
        logic [BYTE_W-1:0] isr;
    } ctrl_regs_t;

    typedef logic [STA_N-1:0][BYTE_W-1:0] sta_arr_t;
    typedef logic [MC_N-1:0][BYTE_W-1:0]  mc_arr_t;
endpackage

// File: rtl/nic_rdma_engine.sv
module nic_rdma_engine
    import nic_regs_pkg::*;
#(
    parameter int AW = RA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              ld_addr_lo,
    input  logic              ld_addr_hi,
    input  logic              ld_cnt_lo,
    input  logic              ld_cnt_hi,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic              start_rd,
    input  logic              start_wr,
    input  logic              step,
    output logic [AW-1:0]     addr,
    output logic [AW-1:0]     cnt,
    output logic              busy,
    output logic              dir_wr,
    output logic              done
);
    localparam int HALF = AW / 2;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [AW-1:0] cnt;
        logic          busy;
        logic          dir_wr;
    } eng_t;

    eng_t st_d, st_q;
    logic start;

    always_comb begin
        st_d  = st_q;
        start = start_rd | start_wr;
        done  = 1'b0;
        if (ld_addr_lo) st_d.addr[HALF-1:0]  = wbyte[HALF-1:0];
        if (ld_addr_hi) st_d.addr[AW-1:HALF] = wbyte[AW-HALF-1:0];
        if (ld_cnt_lo)  st_d.cnt[HALF-1:0]   = wbyte[HALF-1:0];
        if (ld_cnt_hi)  st_d.cnt[AW-1:HALF]  = wbyte[AW-HALF-1:0];
        if (start) begin
            st_d.dir_wr = start_wr;
            st_d.busy   = (st_q.cnt != '0);
            done        = (st_q.cnt == '0);
        end else if (step && st_q.busy) begin
            st_d.addr = st_q.addr + 1'b1;
            st_d.cnt  = st_q.cnt - 1'b1;
            if (st_q.cnt == AW'(1)) begin
                st_d.busy = 1'b0;
                done      = 1'b1;
            end
        end
        if (soft_rst) begin
            st_d.busy = 1'b0;
            done      = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr   = st_q.addr;
    assign cnt    = st_q.cnt;
    assign busy   = st_q.busy;
    assign dir_wr = st_q.dir_wr;
endmodule

// File: rtl/nic_reg_readmux.sv
module nic_reg_readmux
    import nic_regs_pkg::*;
(
    input  logic [OFF_W-1:0]  off,
    input  ctrl_regs_t        regs,
    input  sta_arr_t          sta,
    input  mc_arr_t           mc,
    input  logic [BYTE_W-1:0] rx_stat,
    input  logic [RA_W-1:0]   raddr,
    input  logic [RA_W-1:0]   rcnt,
    output logic [BYTE_W-1:0] data
);
    logic [1:0] page;
    assign page = regs.cmd[7:6];

    always_comb begin
        data = '0;
        if (off == OFF_CMD) begin
            data = regs.cmd;
        end else begin
            unique case (page)
                2'd0: begin
                    case (off)
                        OFF_PSTART: data = regs.pstart;
                        OFF_ISR:    data = regs.isr;
                        OFF_RA_LO:  data = raddr[7:0];
                        OFF_RA_HI:  data = raddr[15:8];
                        OFF_RC_LO:  data = rcnt[7:0];
                        OFF_RC_HI:  data = rcnt[15:8];
                        OFF_RXCFG:  data = rx_stat;
                        default:    data = '0;
                    endcase
                end
                2'd1: begin
                    for (int i = 0; i < STA_N; i++)
                        if (off == OFF_W'(i + 1)) data = sta[i];
                    for (int j = 0; j < MC_N; j++)
                        if (off == OFF_W'(j + 8)) data = mc[j];
                end
                2'd2: begin
                    case (off)
                        OFF_PSTART: data = regs.pstart;
                        OFF_RXCFG:  data = regs.rxcfg;
                        OFF_TXCFG:  data = regs.txcfg;
                        OFF_DCFG:   data = regs.dcfg;
                        OFF_IMASK:  data = regs.imask;
                        default:    data = '0;
                    endcase
                end
                default: data = '0;
            endcase
        end
    end
endmodule

// File: rtl/nic_host_regs.sv
module nic_host_regs
    import nic_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFF_W-1:0]  host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    output logic              irq,
    input  logic [BYTE_W-1:0] rx_stat,
    output logic [RA_W-1:0]   mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata
);
    typedef struct packed {
        ctrl_regs_t        regs;
        sta_arr_t          sta;
        mc_arr_t           mc;
        logic [BYTE_W-1:0] rdata;
        logic              sel_mem;
    } top_t;

    top_t s_d, s_q;

    logic [1:0]        page;
    logic              p0_wr, p1_wr, cmd_wr, srst;
    logic              start_rd, start_wr, step;
    logic              dma_busy, dma_dir_wr, dma_done;
    logic [RA_W-1:0]   dma_addr, dma_cnt;
    logic [BYTE_W-1:0] mux_data;

    assign page     = s_q.regs.cmd[7:6];
    assign cmd_wr   = host_wr && (host_addr == OFF_CMD);
    assign srst     = host_wr && (host_addr == OFF_SRST);
    assign p0_wr    = host_wr && (page == 2'd0);
    assign p1_wr    = host_wr && (page == 2'd1);
    assign start_rd = cmd_wr && (host_wdata[5:3] == XF_READ);
    assign start_wr = cmd_wr && (host_wdata[5:3] == XF_WRITE);
    assign step     = dma_busy && (host_addr == OFF_DATA) &&
                      ((host_rd && !dma_dir_wr) || (host_wr && dma_dir_wr));

    nic_rdma_engine #(.AW(RA_W)) u_dma (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (srst),
        .ld_addr_lo(p0_wr && host_addr == OFF_RA_LO),
        .ld_addr_hi(p0_wr && host_addr == OFF_RA_HI),
        .ld_cnt_lo (p0_wr && host_addr == OFF_RC_LO),
        .ld_cnt_hi (p0_wr && host_addr == OFF_RC_HI),
        .wbyte     (host_wdata),
        .start_rd  (start_rd),
        .start_wr  (start_wr),
        .step      (step),
        .addr      (dma_addr),
        .cnt       (dma_cnt),
        .busy      (dma_busy),
        .dir_wr    (dma_dir_wr),
        .done      (dma_done)
    );

    nic_reg_readmux u_mux (
        .off    (host_addr),
        .regs   (s_q.regs),
        .sta    (s_q.sta),
        .mc     (s_q.mc),
        .rx_stat(rx_stat),
        .raddr  (dma_addr),
        .rcnt   (dma_cnt),
        .data   (mux_data)
    );

    always_comb begin
        s_d = s_q;
        if (cmd_wr) s_d.regs.cmd = host_wdata;
        if (p0_wr) begin
            case (host_addr)
                OFF_PSTART: s_d.regs.pstart = host_wdata;
                OFF_ISR:    s_d.regs.isr    = s_q.regs.isr & ~host_wdata;
                OFF_RXCFG:  s_d.regs.rxcfg  = host_wdata;
                OFF_TXCFG:  s_d.regs.txcfg  = host_wdata;
                OFF_DCFG:   s_d.regs.dcfg   = host_wdata;
                OFF_IMASK:  s_d.regs.imask  = host_wdata;
                default: ;
            endcase
        end
        if (p1_wr) begin
            for (int i = 0; i < STA_N; i++)
                if (host_addr == OFF_W'(i + 1)) s_d.sta[i] = host_wdata;
            for (int j = 0; j < MC_N; j++)
                if (host_addr == OFF_W'(j + 8)) s_d.mc[j] = host_wdata;
        end
        if (dma_done) begin
            s_d.regs.isr[DONE_BIT] = 1'b1;
            s_d.regs.cmd[5:3]      = XF_DONE;
        end
        if (srst) begin
            s_d.regs.cmd = CMD_INIT;
            s_d.regs.isr = '0;
        end
        if (host_rd) begin
            s_d.rdata   = mux_data;
            s_d.sel_mem = step;
        end else begin
            s_d.sel_mem = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.regs.cmd <= CMD_INIT;
        end else begin
            s_q <= s_d;
        end
    end

    assign host_rdata = s_q.sel_mem ? mem_rdata : s_q.rdata;
    assign irq        = |(s_q.regs.isr & s_q.regs.imask);
    assign mem_addr   = dma_addr;
    assign mem_rd     = step && !dma_dir_wr;
    assign mem_wr     = step && dma_dir_wr;
    assign mem_wdata  = host_wdata;
endmodule

// File: rtl/nic_host_regs_chk.sv
module nic_host_regs_chk
    import nic_regs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [OFF_W-1:0]  host_addr,
    input logic              host_wr,
    input logic              host_rd,
    input logic [BYTE_W-1:0] host_wdata,
    input logic [BYTE_W-1:0] cmd,
    input logic [BYTE_W-1:0] isr,
    input logic              busy,
    input logic              dir_wr,
    input logic [RA_W-1:0]   raddr,
    input logic              mem_rd,
    input logic              mem_wr
);
    // R11
    soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == OFF_SRST) |=> (cmd == CMD_INIT && isr == 8'h00));

    // R10
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == OFF_ISR && cmd[7:6] == 2'd0 && host_wdata[DONE_BIT])
        |=> !isr[DONE_BIT]);

    // R6
    read_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == OFF_DATA && busy && !dir_wr && !host_wr)
        |=> (raddr == $past(raddr) + 16'd1));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr));

    // R7
    mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr}));

    // R8
    done_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) && !$past(host_wr && host_addr == OFF_SRST) |-> (cmd[5:3] == XF_DONE && isr[DONE_BIT]));
endmodule

bind nic_host_regs nic_host_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_addr (host_addr),
    .host_wr   (host_wr),
    .host_rd   (host_rd),
    .host_wdata(host_wdata),
    .cmd       (s_q.regs.cmd),
    .isr       (s_q.regs.isr),
    .busy      (dma_busy),
    .dir_wr    (dma_dir_wr),
    .raddr     (dma_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr)
);

// File: tb/nic_host_regs_test.sv
module nic_host_regs_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        irq;
    logic [7:0]  rx_stat = 8'h5C;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic [7:0]  ram [256];

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    logic [7:0] w0 [16];
    logic [7:0] w1 [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    nic_host_regs uut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .irq(irq), .rx_stat(rx_stat), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (mem_wr) ram[mem_addr[7:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= ram[mem_addr[7:0]];
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic hw(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hr(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    function automatic logic [7:0] exp_read(input int p, input int off);
        if (off == 0) return {p[1:0], 6'b100001};
        if (off >= 16) return 8'h00;
        case (p)
            0: case (off)
                   1, 8, 9, 10, 11: return w0[off];
                   12: return rx_stat;
                   default: return 8'h00;
               endcase
            1: if ((off >= 1 && off <= 6) || off >= 8) return w1[off]; else return 8'h00;
            2: if (off == 1 || off >= 12) return w0[off]; else return 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        if (!ended) begin
            ended = 1'b1;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        for (int i = 0; i < 256; i++) ram[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        hr(5'h00, d); chk("R1 cmd", d, 8'h21);
        hr(5'h07, d); chk("R1 isr", d, 8'h00);
        chk("R1 irq", irq, 1'b0);

        // R2 R3 R4 R5 sweep: write every writable offset in every page
        for (int p = 0; p < 4; p++) begin
            hw(5'h00, {p[1:0], 6'b100001});
            for (int off = 1; off < 16; off++) begin
                if (off != 7) begin
                    logic [7:0] v;
                    v = 8'((p * 16 + off) * 3 + 1);
                    hw(5'(off), v);
                    if (p == 0) w0[off] = v;
                    if (p == 1) w1[off] = v;
                end
            end
        end
        // page 0 IMASK written as nonzero: keep status empty so irq stays low
        for (int p = 0; p < 4; p++) begin
            hw(5'h00, {p[1:0], 6'b100001});
            for (int off = 0; off < 32; off++) begin
                hr(5'(off), d);
                case (p)
                    0: chk($sformatf("R3 page0 off %0d", off), d, exp_read(p, off));
                    1: chk($sformatf("R5 page1 off %0d", off), d, exp_read(p, off));
                    2: chk($sformatf("R4 page2 off %0d", off), d, exp_read(p, off));
                    default: chk($sformatf("R2 page3 off %0d", off), d, exp_read(p, off));
                endcase
            end
        end

        // R6 remote read across a 256-byte boundary
        hw(5'h00, 8'h21);
        hw(5'h0F, 8'h00);
        hw(5'h08, 8'hFC); hw(5'h09, 8'h00);
        hw(5'h0A, 8'h06); hw(5'h0B, 8'h00);
        hw(5'h00, 8'h0A);
        for (int i = 0; i < 6; i++) begin
            hr(5'h10, d);
            chk($sformatf("R6 byte %0d", i), d, 8'((8'hFC + i) * 7 + 3));
        end
        hr(5'h08, d); chk("R6 addr lo", d, 8'h02);
        hr(5'h09, d); chk("R6 addr hi", d, 8'h01);
        hr(5'h0A, d); chk("R8 count lo", d, 8'h00);
        hr(5'h00, d); chk("R8 cmd done", d, 8'h22);
        hr(5'h07, d); chk("R8 isr done", d, 8'h40);
        chk("R9 masked", irq, 1'b0);
        hr(5'h10, d); chk("R8 idle read", d, 8'h00);
        hr(5'h08, d); chk("R8 idle no step", d, 8'h02);

        // R9 mask
        hw(5'h0F, 8'h40);
        @(negedge clk); chk("R9 unmasked", irq, 1'b1);
        // R10 write-one-to-clear
        hw(5'h07, 8'hBF);
        hr(5'h07, d); chk("R10 keep", d, 8'h40);
        hw(5'h07, 8'h40);
        hr(5'h07, d); chk("R10 clear", d, 8'h00);
        chk("R9 low", irq, 1'b0);

        // R7 remote write then read back
        hw(5'h08, 8'h30); hw(5'h09, 8'h00);
        hw(5'h0A, 8'h04);
        hw(5'h00, 8'h12);
        for (int i = 0; i < 4; i++) hw(5'h10, 8'(8'hA0 + i));
        @(negedge clk);
        for (int i = 0; i < 4; i++)
            chk($sformatf("R7 ram %0d", i), ram[8'h30 + i], 8'(8'hA0 + i));
        chk("R7 neighbour", ram[8'h34], 8'(8'h34 * 7 + 3));
        hr(5'h00, d); chk("R8 cmd after write", d, 8'h22);
        hw(5'h07, 8'hFF);
        hw(5'h08, 8'h30); hw(5'h0A, 8'h02);
        hw(5'h00, 8'h0A);
        hr(5'h10, d); chk("R12 R6 readback0", d, 8'hA0);
        hr(5'h10, d); chk("R6 readback1", d, 8'hA1);

        // R8 start with zero count
        hw(5'h07, 8'hFF);
        hw(5'h0A, 8'h00); hw(5'h0B, 8'h00);
        hw(5'h00, 8'h0A);
        hr(5'h07, d); chk("R8 zero count isr", d, 8'h40);
        hr(5'h00, d); chk("R8 zero count cmd", d, 8'h22);

        // R11 reset port
        hw(5'h00, 8'h61);
        hw(5'h1F, 8'h5A);
        hr(5'h00, d); chk("R11 cmd", d, 8'h21);
        hr(5'h07, d); chk("R11 isr", d, 8'h00);
        hw(5'h00, 8'hA1);
        hr(5'h0E, d); chk("R11 dcfg kept", d, w0[14]);
        hw(5'h00, 8'h61);
        hr(5'h03, d); chk("R11 station kept", d, w1[3]);

        if (!ended) begin
            ended = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule